// File: doc/BRIEF.md
# Configuration Port Write Sequencer

This block moves configuration data from a wide memory-side producer to a narrow, write-only internal configuration port that runs on its own clock. The producer pushes 256-bit words in the memory clock domain. They go into a dual-clock buffer. On the port clock side, each word is emitted as eight 32-bit words, lowest lane first.

A small read-side sequencer watches the buffer's empty indication. While data is present, it strobes the buffer read. One port-clock cycle later it drives the active-low port select together with a registered data word. When the buffer runs dry, the select releases.

The block does not count bytes. The producer decides how much data to send. To pace itself, the producer uses an exported flag that rises at half occupancy. The port's direction select is held at write.

Top module: `cfg_port_writer`

## Requirements
- R1: While the resets are asserted, `port_csel_n` is 1, `wr_half_full` is 0 and `port_rd_sel` is 0.
- R2: Each accepted 256-bit word appears on `port_data` as eight 32-bit words. Bits [31:0] come first and bits [255:224] come last. Words come out in the order they were pushed.
- R3: `port_csel_n` goes low in the port-clock cycle after the buffer read strobe. `port_data` holds the strobed lane in every cycle where `port_csel_n` is 0.
- R4: `port_csel_n` is 1 in the cycle after any cycle where the buffer looked empty. A single isolated word produces exactly eight consecutive select-low cycles, with no extra lane.
- R5: `port_rd_sel` is 0 in every cycle (0 selects write).
- R6: `wr_half_full` is 1 exactly when the write-side view of stored words is at least DEPTH/2. It rises only on the edge that accepts a push.
- R7: A push offered while DEPTH words are held is dropped, and the level never exceeds DEPTH.
- R8: Pointers cross between domains as Gray code through two-flop synchronisers. A pushed word reaches the port within a bounded number of port-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Memory-side clock |
| wr_rst_n | input | 1 | Active-low reset, memory side |
| wr_valid | input | 1 | Push strobe for `wr_data` |
| wr_data | input | 256 | Wide configuration word |
| wr_half_full | output | 1 | Backpressure flag, high at half occupancy or more |
| port_clk | input | 1 | Configuration port clock |
| port_rst_n | input | 1 | Active-low reset, port side |
| port_data | output | 32 | Registered word to the configuration port |
| port_csel_n | output | 1 | Active-low port select |
| port_rd_sel | output | 1 | Direction select, constant 0 for write |

## Verification
The bench builds the block with DEPTH = 4 and the default 256-to-32 ratio. With this depth, every occupancy level from empty to full, and the dropped push beyond full, can be reached in a handful of writes. The half-full threshold of 2 sits in the middle of that sweep.

Holding the port side in reset while writing freezes the read pointer, so the flag can be stepped level by level. Bursts of one to four words are then swept with the port draining, and every lane is checked against arithmetically generated values.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    localparam int unsigned SYNC_STAGES = 2;

    function automatic int unsigned half_mark(input int unsigned depth);
        return depth / 2;
    endfunction
endpackage

// File: rtl/cfgw_sync.sv
module cfgw_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import cfgw_pkg::*;

    logic [W-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/cfgw_wr_ctl.sv
module cfgw_wr_ctl #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [PW-1:0] rd_gray_sync,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wr_gray,
    output logic [PW-1:0] level,
    output logic          half_full
);
    localparam logic [PW-1:0] HALF = PW'(cfgw_pkg::half_mark(DEPTH));
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          half;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [PW-1:0] rd_bin;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        st_d   = st_q;
        rd_bin = gray_to_bin(rd_gray_sync);
        level  = st_q.ptr - rd_bin;
        push   = valid && (level != FULL);
        if (push) st_d.ptr = st_q.ptr + 1'b1;
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        st_d.half = (st_d.ptr - rd_bin) >= HALF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr     = st_q.ptr[AW-1:0];
    assign wr_gray   = st_q.gray;
    assign half_full = st_q.half;
endmodule

// File: rtl/cfgw_rd_seq.sv
module cfgw_rd_seq #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LANES = 8,
    parameter int unsigned RD_W  = 32,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1,
    localparam int unsigned LW = $clog2(LANES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   wr_gray_sync,
    input  logic [RD_W-1:0] lane_data,
    output logic            rd_en,
    output logic            empty,
    output logic [AW-1:0]   raddr,
    output logic [LW-1:0]   lane,
    output logic [PW-1:0]   rd_gray,
    output logic [RD_W-1:0] port_data,
    output logic            port_csel_n
);
    localparam logic [LW-1:0] LAST = LW'(LANES - 1);

    typedef struct packed {
        logic [PW-1:0]   word;
        logic [LW-1:0]   lane;
        logic [PW-1:0]   gray;
        logic            csel_n;
        logic [RD_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        st_d  = st_q;
        empty = (st_q.word == gray_to_bin(wr_gray_sync));
        rd_en = !empty;
        if (rd_en) begin
            st_d.lane = st_q.lane + 1'b1;
            st_d.data = lane_data;
            if (st_q.lane == LAST) begin
                st_d.lane = '0;
                st_d.word = st_q.word + 1'b1;
            end
        end
        st_d.gray   = st_d.word ^ (st_d.word >> 1);
        st_d.csel_n = !rd_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.csel_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr       = st_q.word[AW-1:0];
    assign lane        = st_q.lane;
    assign rd_gray     = st_q.gray;
    assign port_data   = st_q.data;
    assign port_csel_n = st_q.csel_n;
endmodule

// File: rtl/cfg_port_writer.sv
module cfg_port_writer #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WR_W  = 256,
    parameter int unsigned RD_W  = 32,
    localparam int unsigned LANES = WR_W / RD_W,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1,
    localparam int unsigned LW    = $clog2(LANES)
) (
    input  logic            wr_clk,
    input  logic            wr_rst_n,
    input  logic            wr_valid,
    input  logic [WR_W-1:0] wr_data,
    output logic            wr_half_full,
    input  logic            port_clk,
    input  logic            port_rst_n,
    output logic [RD_W-1:0] port_data,
    output logic            port_csel_n,
    output logic            port_rd_sel
);
    logic [WR_W-1:0] mem [DEPTH];

    logic            wr_push;
    logic [AW-1:0]   waddr;
    logic [PW-1:0]   wr_gray, wr_gray_at_rd, wr_level;
    logic            seq_rd_en, seq_empty;
    logic [AW-1:0]   raddr;
    logic [LW-1:0]   lane;
    logic [PW-1:0]   rd_gray, rd_gray_at_wr;
    logic [WR_W-1:0] rd_word;
    logic [RD_W-1:0] lane_arr [LANES];

    cfgw_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .valid(wr_valid),
        .rd_gray_sync(rd_gray_at_wr), .push(wr_push), .waddr(waddr),
        .wr_gray(wr_gray), .level(wr_level), .half_full(wr_half_full)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_push) mem[waddr] <= wr_data;
    end

    cfgw_sync #(.W(PW)) u_sync_w2r (
        .clk(port_clk), .rst_n(port_rst_n), .d(wr_gray), .q(wr_gray_at_rd)
    );

    cfgw_sync #(.W(PW)) u_sync_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_at_wr)
    );

    assign rd_word = mem[raddr];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_arr[g] = rd_word[g*RD_W +: RD_W];
    end

    cfgw_rd_seq #(.DEPTH(DEPTH), .LANES(LANES), .RD_W(RD_W)) u_seq (
        .clk(port_clk), .rst_n(port_rst_n), .wr_gray_sync(wr_gray_at_rd),
        .lane_data(lane_arr[lane]), .rd_en(seq_rd_en), .empty(seq_empty),
        .raddr(raddr), .lane(lane), .rd_gray(rd_gray),
        .port_data(port_data), .port_csel_n(port_csel_n)
    );

    assign port_rd_sel = 1'b0;
endmodule

// File: rtl/cfgw_chk.sv
module cfgw_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW = $clog2(DEPTH) + 1
) (
    input logic          port_clk,
    input logic          port_rst_n,
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_en,
    input logic          empty,
    input logic          port_csel_n,
    input logic          wr_push,
    input logic          wr_half_full,
    input logic [PW-1:0] wr_level
);
    AST_CSEL_AFTER_STROBE: assert property (@(posedge port_clk) disable iff (!port_rst_n)
        rd_en |=> !port_csel_n); // R3

    AST_IDLE_WHEN_EMPTY: assert property (@(posedge port_clk) disable iff (!port_rst_n)
        empty |=> port_csel_n); // R4

    AST_HALF_RISES_ON_PUSH: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(wr_half_full) |-> $past(wr_push)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_level <= PW'(DEPTH)); // R7
endmodule

bind cfg_port_writer cfgw_chk #(.DEPTH(DEPTH)) u_chk (
    .port_clk(port_clk), .port_rst_n(port_rst_n),
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n),
    .rd_en(seq_rd_en), .empty(seq_empty), .port_csel_n(port_csel_n),
    .wr_push(wr_push), .wr_half_full(wr_half_full), .wr_level(wr_level)
);

// File: tb/cfg_port_writer_bench.sv
module cfg_port_writer_bench;
    localparam int DEPTH = 4;

    logic         wr_clk = 0, port_clk = 0;
    logic         wr_rst_n = 0, port_rst_n = 0;
    logic         wr_valid = 0;
    logic [255:0] wr_data = '0;
    logic         wr_half_full;
    logic [31:0]  port_data;
    logic         port_csel_n, port_rd_sel;

    int checks = 0, errors = 0;
    logic [31:0] exp_mem [0:255];
    int exp_n = 0, got_n = 0, run = 0, last_run = 0, dir_bad = 0;
    bit done = 0;

    always #5 port_clk = ~port_clk;
    always #3 wr_clk   = ~wr_clk;

    cfg_port_writer #(.DEPTH(DEPTH)) u_cfg_port_writer (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_half_full(wr_half_full),
        .port_clk(port_clk), .port_rst_n(port_rst_n), .port_data(port_data),
        .port_csel_n(port_csel_n), .port_rd_sel(port_rd_sel)
    );

    function automatic logic [31:0] lane_val(input int w, input int l);
        return {8'(w * 37 + 5), 8'(l), 16'((w * 1021) ^ (l * 77) ^ 16'h5A3C)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2 R3 R5: monitor every port cycle away from the rising edge
    always @(negedge port_clk) begin
        if (port_rst_n) begin
            if (port_rd_sel !== 1'b0) dir_bad++;
            if (port_csel_n === 1'b0) begin
                run++;
                if (got_n < exp_n) check(port_data === exp_mem[got_n], "R2/R3 lane data", port_data, exp_mem[got_n]);
                else check(0, "R4 extra lane", 32'(got_n), 32'(exp_n));
                got_n++;
            end else if (run != 0) begin
                last_run = run;
                run = 0;
            end
        end
    end

    task automatic push_word(input int w, input bit accepted);
        @(negedge wr_clk);
        for (int l = 0; l < 8; l++) begin
            wr_data[l*32 +: 32] = lane_val(w, l);
            if (accepted) exp_mem[exp_n + l] = lane_val(w, l);
        end
        if (accepted) exp_n += 8;
        wr_valid = 1;
        @(negedge wr_clk);
        wr_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge port_clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", got_n, exp_n);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w = 0;
        repeat (4) @(negedge port_clk);
        check(port_csel_n === 1'b1, "R1 select idle", 32'(port_csel_n), 1);
        check(wr_half_full === 1'b0, "R1 half flag", 32'(wr_half_full), 0);
        check(port_rd_sel === 1'b0, "R1 direction", 32'(port_rd_sel), 0);

        // Port side held in reset: read pointer frozen, step the level (R6, R7)
        wr_rst_n = 1;
        repeat (4) @(negedge wr_clk);
        for (int k = 1; k <= DEPTH; k++) begin
            push_word(w, 1); w++;
            check(wr_half_full === (k >= DEPTH / 2), "R6 half flag at level", 32'(wr_half_full), 32'(k >= DEPTH / 2));
        end
        push_word(99, 0); // R7: dropped while full
        check(wr_half_full === 1'b1, "R7 flag held when full", 32'(wr_half_full), 1);

        port_rst_n = 1;
        repeat (120) @(negedge port_clk);
        check(got_n == exp_n, "R7 R8 lanes after full drain", 32'(got_n), 32'(exp_n));
        check(port_csel_n === 1'b1, "R4 idle after drain", 32'(port_csel_n), 1);
        check(wr_half_full === 1'b0, "R6 flag clears after drain", 32'(wr_half_full), 0);

        // Burst sweep with the port draining
        for (int n = 1; n <= DEPTH; n++) begin
            for (int j = 0; j < n; j++) begin push_word(w, 1); w++; end
            repeat (120) @(negedge port_clk);
            check(got_n == exp_n, "R2 R8 lane count per burst", 32'(got_n), 32'(exp_n));
            check(port_csel_n === 1'b1, "R4 select released", 32'(port_csel_n), 1);
            if (n == 1) check(last_run == 8, "R4 single word run", 32'(last_run), 8);
        end
        check(dir_bad == 0, "R5 direction always write", 32'(dir_bad), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule